// File: doc/BRIEF.md
# Chained Byte Scrambler / Descrambler

This block obfuscates or restores a stream of bytes, one byte per clock, for short command and reply packets. Each byte goes through a fixed sequence of XOR and modulo-256 subtract (or add) stages. Two 8-bit chain registers are mixed into that sequence, so every output byte depends on the bytes that came before it in the same packet. One chain register holds the previous plaintext byte and the other holds the previous ciphertext byte. A single `mode` input picks the direction for each accepted byte. The decode direction is the exact inverse of the encode direction, so a decoder started from the same seeds recovers the original bytes.

Bytes arrive on a valid/ready input and leave from a registered valid/ready output. An accepted byte shows up on the output one cycle later. Back-pressure rules are simple:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output byte is held and no new byte is taken in.

The `in_sop` input marks the first byte of a packet. That byte is processed with the chain registers forced to their seeds, and the chain then continues from it. Framing, length limits and the transport belong to the surrounding logic.

Top module: `byte_chain_scrambler`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the chain registers hold the seeds (plaintext chain 0x9B, ciphertext chain 0x54). Encoding plaintext 0x00 as the first byte after reset, without `in_sop`, therefore yields 0xDA.
- R2: With `mode`=0 (encode), and with all arithmetic modulo 256, each accepted byte p maps to ciphertext c as follows. First, u = (((p ^ Kc ^ 0x2B) - 0x05) ^ 0x35) - 0x39. Then c = (((u ^ Kp ^ 0x5A) - 0xB0) ^ 0x38) - 0x45. Here Kp is the plaintext chain register and Kc is the ciphertext chain register.
- R3: With `mode`=1 (decode), each accepted byte c maps to plaintext p as follows. First, u = (((c + 0x45) ^ 0x38) + 0xB0) ^ 0x5A ^ Kp. Then p = (((u + 0x39) ^ 0x35) + 0x05) ^ 0x2B ^ Kc.
- R4: After every accepted byte, in either mode, Kp takes that byte's plaintext and Kc takes that byte's ciphertext.
- R5: A byte accepted with `in_sop`=1 is processed with Kp=0x9B and Kc=0x54, whatever the chain held before. The chain then continues from that byte.
- R6: `in_ready` equals (!`out_valid` || `out_ready`). A byte accepted at a clock edge is presented, with `out_valid`=1, right after that edge. Bytes can be accepted on every cycle.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: A cycle with `in_valid`=0 changes neither chain register, whatever `in_data`, `in_sop` and `mode` carry. When the output is being drained in such a cycle, `out_valid` falls to 0.
- R9: Decoding, from the seeds, the ciphertext produced by encoding from the seeds returns the original plaintext bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = encode, 1 = decode; sampled with each accepted byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Processed output byte |

## Verification
The hardest situation to reach from the ports is a byte that is offered while the output is stalled. That byte must not advance the chain until it is really accepted. Otherwise every later byte in the packet is corrupted, even though the stalled output itself looks correct.

The bench creates this case by holding `out_ready` low after one accepted byte and offering a second byte with `in_valid` high for several cycles. It then releases `out_ready` and checks the second byte, and the bytes after it, against a model that advances only on real handshakes. Idle cycles carrying junk data are handled the same way: the first byte after them must continue the chain unchanged.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    DIR_ENCODE = 1'b0,
    DIR_DECODE = 1'b1
  } dir_e;

  // mixing constants of the inner (ciphertext-chain) stage
  localparam byte_t IN_XOR_0 = 8'h2b;
  localparam byte_t IN_SUB_0 = 8'h05;
  localparam byte_t IN_XOR_1 = 8'h35;
  localparam byte_t IN_SUB_1 = 8'h39;
  // mixing constants of the outer (plaintext-chain) stage
  localparam byte_t OUT_XOR_0 = 8'h5a;
  localparam byte_t OUT_SUB_0 = 8'hb0;
  localparam byte_t OUT_XOR_1 = 8'h38;
  localparam byte_t OUT_SUB_1 = 8'h45;

  localparam byte_t DEF_SEED_P = 8'h9b;
  localparam byte_t DEF_SEED_C = 8'h54;
endpackage

// File: rtl/scr_encode_core.sv
module scr_encode_core
  import scr_pkg::*;
(
  input  byte_t plain_i,
  input  byte_t key_p_i,
  input  byte_t key_c_i,
  output byte_t cipher_o
);
  byte_t s0, s1, s2, s3, s4, s5, s6;

  always_comb begin
    // inner stage, mixed with the ciphertext chain
    s0 = plain_i ^ key_c_i ^ IN_XOR_0;
    s1 = s0 - IN_SUB_0;
    s2 = s1 ^ IN_XOR_1;
    s3 = s2 - IN_SUB_1;
    // outer stage, mixed with the plaintext chain
    s4 = s3 ^ key_p_i ^ OUT_XOR_0;
    s5 = s4 - OUT_SUB_0;
    s6 = s5 ^ OUT_XOR_1;
    cipher_o = s6 - OUT_SUB_1;
  end
endmodule

// File: rtl/scr_decode_core.sv
module scr_decode_core
  import scr_pkg::*;
(
  input  byte_t cipher_i,
  input  byte_t key_p_i,
  input  byte_t key_c_i,
  output byte_t plain_o
);
  byte_t s0, s1, s2, s3, s4, s5, s6;

  always_comb begin
    // undo the outer stage
    s0 = cipher_i + OUT_SUB_1;
    s1 = s0 ^ OUT_XOR_1;
    s2 = s1 + OUT_SUB_0;
    s3 = s2 ^ OUT_XOR_0 ^ key_p_i;
    // undo the inner stage
    s4 = s3 + IN_SUB_1;
    s5 = s4 ^ IN_XOR_1;
    s6 = s5 + IN_SUB_0;
    plain_o = s6 ^ IN_XOR_0 ^ key_c_i;
  end
endmodule

// File: rtl/scr_chain_state.sv
module scr_chain_state
  import scr_pkg::*;
#(
  parameter byte_t SEED_P = DEF_SEED_P,
  parameter byte_t SEED_C = DEF_SEED_C
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_i,
  input  logic  sop_i,
  input  byte_t plain_i,
  input  byte_t cipher_i,
  output byte_t key_p_o,
  output byte_t key_c_o
);
  byte_t chain_p_q, chain_c_q;

  // a packet start overrides the chain with the seeds for that byte
  assign key_p_o = sop_i ? SEED_P : chain_p_q;
  assign key_c_o = sop_i ? SEED_C : chain_c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_p_q <= SEED_P;
      chain_c_q <= SEED_C;
    end else if (take_i) begin
      chain_p_q <= plain_i;
      chain_c_q <= cipher_i;
    end
  end
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  byte_t data_i,
  input  logic  ready_i,
  output logic  space_o,
  output logic  valid_o,
  output byte_t data_o
);
  logic  valid_q;
  byte_t data_q;

  assign space_o = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_chain_scrambler.sv
module byte_chain_scrambler
  import scr_pkg::*;
#(
  parameter logic [7:0] SEED_P = DEF_SEED_P,
  parameter logic [7:0] SEED_C = DEF_SEED_C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic  take;
  logic  room;
  byte_t key_p, key_c;
  byte_t enc_out, dec_out;
  byte_t plain_b, cipher_b, result_b;
  dir_e  dir;

  assign dir      = dir_e'(mode);
  assign in_ready = room;
  assign take     = in_valid && room;

  scr_chain_state #(.SEED_P(SEED_P), .SEED_C(SEED_C)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .sop_i    (in_sop),
    .plain_i  (plain_b),
    .cipher_i (cipher_b),
    .key_p_o  (key_p),
    .key_c_o  (key_c)
  );

  scr_encode_core u_enc (
    .plain_i  (in_data),
    .key_p_i  (key_p),
    .key_c_i  (key_c),
    .cipher_o (enc_out)
  );

  scr_decode_core u_dec (
    .cipher_i (in_data),
    .key_p_i  (key_p),
    .key_c_i  (key_c),
    .plain_o  (dec_out)
  );

  always_comb begin
    if (dir == DIR_DECODE) begin
      plain_b  = dec_out;
      cipher_b = in_data;
      result_b = dec_out;
    end else begin
      plain_b  = in_data;
      cipher_b = enc_out;
      result_b = enc_out;
    end
  end

  scr_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (take),
    .data_i  (result_b),
    .ready_i (out_ready),
    .space_o (room),
    .valid_o (out_valid),
    .data_o  (out_data)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sop,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  // R6
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R6
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  // R5
  sop_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop && !mode && in_data == 8'h00) |=> (out_data == 8'hda));

  // R5
  sop_seed_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop && mode && in_data == 8'hda) |=> (out_data == 8'h00));
endmodule

bind byte_chain_scrambler scr_checker u_chk (.*);

// File: tb/tb_byte_chain_scrambler.sv
module tb_byte_chain_scrambler;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode;
  logic       in_valid;
  logic       in_ready;
  logic       in_sop;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mp, mc;  // bench model of the chain
  logic [7:0] plain_mem [16];
  logic [7:0] ciph_mem  [16];

  always #10 clk = ~clk;

  byte_chain_scrambler dut (.*);

  function automatic logic [7:0] enc_f(input logic [7:0] p, input logic [7:0] kp, input logic [7:0] kc);
    logic [7:0] u;
    u = (((p ^ kc ^ 8'h2b) - 8'h05) ^ 8'h35) - 8'h39;
    return (((u ^ kp ^ 8'h5a) - 8'hb0) ^ 8'h38) - 8'h45;
  endfunction

  function automatic logic [7:0] dec_f(input logic [7:0] c, input logic [7:0] kp, input logic [7:0] kc);
    logic [7:0] u;
    u = (((c + 8'h45) ^ 8'h38) + 8'hb0) ^ 8'h5a ^ kp;
    return (((u + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2b ^ kc;
  endfunction

  // model one accepted byte, returns expected output
  function automatic logic [7:0] model(input logic sop, input logic md, input logic [7:0] d);
    logic [7:0] r;
    if (sop) begin mp = 8'h9b; mc = 8'h54; end
    if (!md) begin r = enc_f(d, mp, mc); mp = d; mc = r; end
    else     begin r = dec_f(d, mp, mc); mp = r; mc = d; end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // single byte transfer with out_ready high; checks output
  task automatic xfer(input string req, input logic sop, input logic md, input logic [7:0] d);
    logic [7:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_sop = sop; mode = md; in_data = d; out_ready = 1'b1;
    e = model(sop, md, d);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    check({req, " valid"}, {7'd0, out_valid}, 8'd1);
    check(req, out_data, e);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; mode = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mp = 8'h9b; mc = 8'h54;
    #1;
    check("R1 out_valid", {7'd0, out_valid}, 8'd0);
    check("R1 in_ready", {7'd0, in_ready}, 8'd1);
  endtask

  task automatic t_seed_vector;
    xfer("R1 R2 seeded first byte", 1'b0, 1'b0, 8'h00);
    check("R1 literal", out_data, 8'hda);
  endtask

  task automatic t_encode_packet;
    for (int i = 0; i < 8; i++) begin
      plain_mem[i] = 8'(i * 37 + 5);
      xfer("R2 R4 encode", i == 0, 1'b0, plain_mem[i]);
      ciph_mem[i] = out_data;
    end
  endtask

  task automatic t_decode_packet;
    for (int i = 0; i < 8; i++) begin
      xfer("R3 R4 decode", i == 0, 1'b1, ciph_mem[i]);
      check("R9 roundtrip", out_data, plain_mem[i]);
    end
  endtask

  task automatic t_stream;
    logic [7:0] exp_q [17];
    for (int i = 0; i <= 16; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      if (i > 0) begin
        check("R6 stream valid", {7'd0, out_valid}, 8'd1);
        check("R6 stream data", out_data, exp_q[i-1]);
      end
      if (i < 16) begin
        in_valid = 1'b1; in_sop = (i == 0); mode = i[2]; in_data = 8'(i * 11 + 3);
        exp_q[i] = model(in_sop, mode, in_data);
      end else begin
        in_valid = 1'b0; in_sop = 1'b0;
      end
      @(posedge clk);
    end
  endtask

  task automatic t_stall;
    logic [7:0] e0, e1;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_sop = 1'b1; mode = 1'b0; in_data = 8'h3c;
    e0 = model(1'b1, 1'b0, 8'h3c);
    @(posedge clk);
    @(negedge clk);
    in_sop = 1'b0; in_data = 8'hc3;
    #1;
    check("R6 in_ready low in stall", {7'd0, in_ready}, 8'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R7 stall valid", {7'd0, out_valid}, 8'd1);
      check("R7 stall data", out_data, e0);
    end
    out_ready = 1'b1;
    #1;
    check("R6 in_ready on drain", {7'd0, in_ready}, 8'd1);
    e1 = model(1'b0, 1'b0, 8'hc3);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 R4 byte after stall", out_data, e1);
    xfer("R4 chain after stall", 1'b0, 1'b0, 8'h77);
  endtask

  task automatic t_idle_ignored;
    xfer("R2 before idle", 1'b1, 1'b0, 8'h10);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b1; mode = 1'b1; in_data = 8'hff; out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 drained", {7'd0, out_valid}, 8'd0);
    in_sop = 1'b0;
    xfer("R8 chain kept over idle", 1'b0, 1'b0, 8'h20);
  endtask

  task automatic t_sop_mid;
    xfer("R5 pre", 1'b1, 1'b0, 8'h55);
    xfer("R5 pre2", 1'b0, 1'b0, 8'haa);
    xfer("R5 reseed mid-stream", 1'b1, 1'b0, 8'h00);
    check("R5 literal", out_data, 8'hda);
    xfer("R5 reseed decode", 1'b1, 1'b1, 8'hda);
    check("R5 decode literal", out_data, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_seed_vector();
    t_encode_packet();
    t_decode_packet();
    t_stream();
    t_stall();
    t_idle_ignored();
    t_sop_mid();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule